// File: doc/BRIEF.md
# Fixed-Head Disk Controller Command and Status Registers

This block sits between an 18-bit programmed-I/O bus and the transfer sequencer of a fixed-head disk controller. Each bus instruction arrives as a one-cycle strobe. It carries a device-group select, three phase bits (test, read, load) that may be combined, a 2-bit sub-opcode and an 18-bit write word. The block applies the phases in the order test, read, load. It holds an 18-bit status word with the function and interrupt-enable fields, a 21-bit disk address made of an 18-bit low part and a 3-bit high part, and an 18-bit data buffer. From these it forms the error summary, the interrupt request and the skip response.

A small state machine handles the hand-off to the sequencer. In `ST_IDLE` an accepted start command with a function other than no-op moves it to `ST_REQUEST`, where `start_req` is driven. When `xfer_busy` is seen it moves to `ST_ACTIVE`. When `xfer_busy` drops it returns to `ST_IDLE`. A controller clear forces `ST_IDLE` from any state. Whenever the machine is not in `ST_IDLE`, the controller counts as busy. The sequencer reports events through `xfer_flags` and `xfer_done`, which set bits in the status word.

Commands on group 0 (`io_dev`=0):
- Test phase: sub-opcode 0 is skip test, 1 is controller clear, 2 is clear function.
- Read phase: sub-opcode 0 reads the buffer, 1 reads the low address, 2 XOR-loads the function field, 3 reads the high address.
- Load phase: sub-opcode 0 loads the buffer, 1 loads the low address, 2 is start, 3 loads the high address.

Commands on group 1 (`io_dev`=1), read phase only: sub-opcode 2 is clear errors and sub-opcode 3 reads the status word. Every other combination has no effect.

Top module: `dsk_csr`

## Requirements
- R1: After reset, and in the cycle after a controller clear issued in any state, the status word, the disk address and the data buffer are zero and the state machine is in `ST_IDLE`.
- R2: The status word has these bits:
  - bits 16..9, set by `xfer_flags[7:0]` in that order: hardware 16, address parity 15, missed transfer 14, write check 13, data parity 12, write lock 11, nonexistent disk 10, channel timing 9.
  - bit 8: programming error.
  - bit 7: done.
  - bits 2:1: function.
  - bit 0: interrupt enable.
  - bits 6:3 always read zero.
  - bit 17 reads as the OR of bits 16..10. Bits 9 and 8 do not contribute to it.
- R3: `irq` is high exactly when (bit 17 or bit 7) and bit 0 are set.
- R4: The function XOR-load inverts status bits 2:0 wherever `io_wdata[2:0]` is 1. The function codes are 0 no-op, 1 read, 2 write, 3 write-check.
- R5: Outside `ST_IDLE`, every group-0 read or load, clear function and clear errors changes no register except that it sets bit 8, and its read returns zero. A status read still returns the status word, with bit 8 now set.
- R6: Start clears done and, if the function is not 0, moves `ST_IDLE` to `ST_REQUEST`. `start_req` then stays high until `xfer_busy` is seen.
- R7: Buffer and low-address loads and reads carry 18 bits. The high-address load takes `io_wdata[2:0]` into address bits 20:18. The high-address read returns those bits in 2:0 and the nonexistent-disk flag in bit 3.
- R8: A high-address load whose value is at or above `platters` sets the nonexistent-disk flag. A lower value leaves the flag as it was.
- R9: Clear errors keeps only bits 2:0. Clear function zeroes only bits 2:0.
- R10: The skip test returns `io_skip`=1 exactly when bit 17 or bit 7 is set.
- R11: `io_rdata` and `io_skip` are registered. They are valid in the cycle after the strobe and are zero in every cycle that follows a cycle with no strobe.
- R12: Within one instruction the read phase sees the effect of the test phase, and the load phase comes after the read. A combined read-and-load returns the old value, and a clear combined with a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_strobe | input | 1 | One-cycle instruction valid |
| io_dev | input | 1 | Device group select |
| io_pulse | input | 3 | Phase bits: 0 test, 1 read, 2 load |
| io_subop | input | 2 | Sub-opcode |
| io_wdata | input | 18 | Write word |
| io_rdata | output | 18 | Read word, registered |
| io_skip | output | 1 | Skip response, registered |
| irq | output | 1 | Interrupt request |
| start_req | output | 1 | Transfer start request |
| xfer_func | output | 2 | Current function field |
| disk_addr | output | 21 | Current disk address |
| xfer_busy | input | 1 | Sequencer busy |
| xfer_done | input | 1 | Sequencer completion pulse |
| xfer_flags | input | 8 | Sequencer error flags, set status bits 16..9 |
| platters | input | 4 | Configured platter count, 1 to 8 |

## Verification
Register loads and the state change after a strobe take effect at the clock edge that samples the strobe. `irq`, `xfer_func`, `disk_addr` and `start_req` therefore change one cycle after the strobe, and so do the registered `io_rdata` and `io_skip`. The sequencer's flags and done pulse reach the status word at the edge that samples them. The bench drives inputs on falling edges and keeps a behavioural reference model that it updates on rising edges. It compares every output on each falling edge, which is exactly one edge after the stimulus. The directed checks read their results at the falling edge that follows the instruction's sampling edge.

// File: rtl/dsk_csr_pkg.sv
package dsk_csr_pkg;

    // status word bit positions (decoded by software, kept fixed)
    localparam int B_SUMM = 17;
    localparam int B_HWE  = 16;
    localparam int B_NXD  = 10;
    localparam int B_DCH  = 9;
    localparam int B_PGE  = 8;
    localparam int B_DONE = 7;
    localparam int FN_HI  = 2;
    localparam int FN_LO  = 1;
    localparam int B_IE   = 0;
    localparam int ERR_N  = B_HWE - B_DCH + 1;

    typedef enum logic [1:0] {
        FN_NOP   = 2'd0,
        FN_READ  = 2'd1,
        FN_WRITE = 2'd2,
        FN_CHECK = 2'd3
    } func_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_REQUEST = 2'd1,
        ST_ACTIVE  = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic skip_test;
        logic ctl_clear;
        logic fn_clear;
        logic rd_buf;
        logic rd_alo;
        logic fn_xor;
        logic rd_ahi;
        logic rd_stat;
        logic err_clear;
        logic ld_buf;
        logic ld_alo;
        logic go;
        logic ld_ahi;
    } csr_cmd_t;

endpackage

// File: rtl/dsk_csr_decode.sv
module dsk_csr_decode
    import dsk_csr_pkg::*;
(
    input  logic       strobe,
    input  logic       dev,
    input  logic [2:0] pulse,
    input  logic [1:0] subop,
    output csr_cmd_t   cmd
);

    always_comb begin
        cmd = '0;
        if (strobe) begin
            if (!dev) begin
                if (pulse[0]) begin
                    unique case (subop)
                        2'd0:    cmd.skip_test = 1'b1;
                        2'd1:    cmd.ctl_clear = 1'b1;
                        2'd2:    cmd.fn_clear  = 1'b1;
                        default: ;
                    endcase
                end
                if (pulse[1]) begin
                    unique case (subop)
                        2'd0:    cmd.rd_buf = 1'b1;
                        2'd1:    cmd.rd_alo = 1'b1;
                        2'd2:    cmd.fn_xor = 1'b1;
                        default: cmd.rd_ahi = 1'b1;
                    endcase
                end
                if (pulse[2]) begin
                    unique case (subop)
                        2'd0:    cmd.ld_buf = 1'b1;
                        2'd1:    cmd.ld_alo = 1'b1;
                        2'd2:    cmd.go     = 1'b1;
                        default: cmd.ld_ahi = 1'b1;
                    endcase
                end
            end else if (pulse[1]) begin
                unique case (subop)
                    2'd2:    cmd.err_clear = 1'b1;
                    2'd3:    cmd.rd_stat   = 1'b1;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/dsk_csr_fsm.sv
module dsk_csr_fsm
    import dsk_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_clear,
    input  logic       launch,
    input  logic       xfer_busy,
    output logic       start_req,
    output logic       blocked,
    output ctl_state_e state
);

    ctl_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        if (ctl_clear) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    if (launch)     state_d = ST_REQUEST;
                ST_REQUEST: if (xfer_busy)  state_d = ST_ACTIVE;
                ST_ACTIVE:  if (!xfer_busy) state_d = ST_IDLE;
                default:                    state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        start_req = (state == ST_REQUEST);
        blocked   = (state != ST_IDLE);
    end

endmodule

// File: rtl/dsk_csr_regs.sv
module dsk_csr_regs
    import dsk_csr_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int ADDR_W = 21,
    parameter int PLAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  csr_cmd_t          cmd,
    input  logic              blocked,
    input  logic [WORD_W-1:0] wdata,
    input  logic [PLAT_W-1:0] platters,
    input  logic              xfer_done,
    input  logic [ERR_N-1:0]  xfer_flags,
    output logic              launch,
    output logic [WORD_W-1:0] rdata,
    output logic              skip,
    output logic [WORD_W-1:0] status,
    output logic [ADDR_W-1:0] disk_addr
);

    localparam int ALO_W = WORD_W;
    localparam int AHI_W = ADDR_W - ALO_W;
    localparam int CMP_W = AHI_W + PLAT_W;

    logic [WORD_W-1:0] stat_q, stat_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [WORD_W-1:0] buf_q, buf_d;
    logic [WORD_W-1:0] rd_d;
    logic              sk_d;
    logic              blk;
    logic [CMP_W-1:0]  hi_ext, plat_ext;

    always_comb begin
        stat_d   = stat_q;
        addr_d   = addr_q;
        buf_d    = buf_q;
        rd_d     = '0;
        sk_d     = 1'b0;
        blk      = blocked;
        launch   = 1'b0;
        hi_ext   = CMP_W'(wdata[AHI_W-1:0]);
        plat_ext = CMP_W'(platters);

        // test phase
        if (cmd.skip_test)
            sk_d = (|stat_q[B_HWE:B_NXD]) | stat_q[B_DONE];
        if (cmd.ctl_clear) begin
            stat_d = '0;
            addr_d = '0;
            buf_d  = '0;
            blk    = 1'b0;
        end
        if (cmd.fn_clear) begin
            if (blk) stat_d[B_PGE] = 1'b1;
            else     stat_d[FN_HI:B_IE] = '0;
        end

        // read phase
        if (cmd.rd_buf || cmd.rd_alo || cmd.fn_xor || cmd.rd_ahi) begin
            if (blk) begin
                stat_d[B_PGE] = 1'b1;
            end else begin
                if (cmd.rd_buf) rd_d = buf_d;
                if (cmd.rd_alo) rd_d = WORD_W'(addr_d[ALO_W-1:0]);
                if (cmd.fn_xor)
                    stat_d[FN_HI:B_IE] = stat_d[FN_HI:B_IE] ^ wdata[FN_HI:B_IE];
                if (cmd.rd_ahi) begin
                    rd_d[AHI_W-1:0] = addr_d[ADDR_W-1:ALO_W];
                    rd_d[AHI_W]     = stat_d[B_NXD];
                end
            end
        end
        if (cmd.err_clear) begin
            if (blk) begin
                stat_d[B_PGE] = 1'b1;
            end else begin
                stat_d = '0;
                stat_d[FN_HI:B_IE] = stat_q[FN_HI:B_IE];
            end
        end
        if (cmd.rd_stat) begin
            if (blk) stat_d[B_PGE] = 1'b1;
            rd_d         = stat_d;
            rd_d[B_SUMM] = |stat_d[B_HWE:B_NXD];
        end

        // load phase
        if (cmd.ld_buf || cmd.ld_alo || cmd.go || cmd.ld_ahi) begin
            if (blk) begin
                stat_d[B_PGE] = 1'b1;
            end else begin
                if (cmd.ld_buf) buf_d = wdata;
                if (cmd.ld_alo) addr_d[ALO_W-1:0] = wdata[ALO_W-1:0];
                if (cmd.go) begin
                    stat_d[B_DONE] = 1'b0;
                    if (stat_d[FN_HI:FN_LO] != FN_NOP) launch = 1'b1;
                end
                if (cmd.ld_ahi) begin
                    addr_d[ADDR_W-1:ALO_W] = wdata[AHI_W-1:0];
                    if (hi_ext >= plat_ext) stat_d[B_NXD] = 1'b1;
                end
            end
        end

        // sequencer events
        stat_d[B_HWE:B_DCH] = stat_d[B_HWE:B_DCH] | xfer_flags;
        if (xfer_done) stat_d[B_DONE] = 1'b1;

        // bits that are never stored
        stat_d[B_SUMM]         = 1'b0;
        stat_d[B_DONE-1:FN_HI+1] = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            addr_q <= '0;
            buf_q  <= '0;
            rdata  <= '0;
            skip   <= 1'b0;
        end else begin
            stat_q <= stat_d;
            addr_q <= addr_d;
            buf_q  <= buf_d;
            rdata  <= rd_d;
            skip   <= sk_d;
        end
    end

    always_comb begin
        status         = stat_q;
        status[B_SUMM] = |stat_q[B_HWE:B_NXD];
        disk_addr      = addr_q;
    end

endmodule

// File: rtl/dsk_csr.sv
module dsk_csr
    import dsk_csr_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int ADDR_W = 21,
    parameter int PLAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_strobe,
    input  logic              io_dev,
    input  logic [2:0]        io_pulse,
    input  logic [1:0]        io_subop,
    input  logic [WORD_W-1:0] io_wdata,
    output logic [WORD_W-1:0] io_rdata,
    output logic              io_skip,
    output logic              irq,
    output logic              start_req,
    output logic [1:0]        xfer_func,
    output logic [ADDR_W-1:0] disk_addr,
    input  logic              xfer_busy,
    input  logic              xfer_done,
    input  logic [ERR_N-1:0]  xfer_flags,
    input  logic [PLAT_W-1:0] platters
);

    csr_cmd_t          cmd;
    logic              launch;
    logic              blocked;
    logic [WORD_W-1:0] status;
    ctl_state_e        ctl_state;

    dsk_csr_decode u_decode (
        .strobe (io_strobe),
        .dev    (io_dev),
        .pulse  (io_pulse),
        .subop  (io_subop),
        .cmd    (cmd)
    );

    dsk_csr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_clear (cmd.ctl_clear),
        .launch    (launch),
        .xfer_busy (xfer_busy),
        .start_req (start_req),
        .blocked   (blocked),
        .state     (ctl_state)
    );

    dsk_csr_regs #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W),
        .PLAT_W (PLAT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .blocked    (blocked),
        .wdata      (io_wdata),
        .platters   (platters),
        .xfer_done  (xfer_done),
        .xfer_flags (xfer_flags),
        .launch     (launch),
        .rdata      (io_rdata),
        .skip       (io_skip),
        .status     (status),
        .disk_addr  (disk_addr)
    );

    always_comb begin
        xfer_func = status[FN_HI:FN_LO];
        irq       = (status[B_SUMM] | status[B_DONE]) & status[B_IE];
    end

endmodule

// File: rtl/dsk_csr_chk.sv
module dsk_csr_chk
    import dsk_csr_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_strobe,
    input logic              io_dev,
    input logic [2:0]        io_pulse,
    input logic [1:0]        io_subop,
    input logic [WORD_W-1:0] io_wdata,
    input logic [WORD_W-1:0] io_rdata,
    input logic              io_skip,
    input logic              start_req,
    input logic [1:0]        xfer_func,
    input logic [ADDR_W-1:0] disk_addr,
    input logic              xfer_busy,
    input ctl_state_e        ctl_state
);

    logic is_clear;
    assign is_clear = io_strobe && !io_dev && io_pulse[0] && (io_subop == 2'd1);

    assert_quiet_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !io_strobe |=> (io_rdata == '0 && !io_skip));

    assert_ctl_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        is_clear |=> (disk_addr == '0 && !start_req && xfer_func == 2'd0));

    assert_fn_xor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe && !io_dev && io_pulse == 3'b010 && io_subop == 2'd2 && ctl_state == ST_IDLE)
        |=> (xfer_func == ($past(xfer_func) ^ $past(io_wdata[2:1]))));

    assert_blocked_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe && !io_dev && io_pulse == 3'b100 && ctl_state != ST_IDLE)
        |=> $stable(disk_addr));

    assert_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe && !io_dev && io_pulse == 3'b100 && io_subop == 2'd2
         && ctl_state == ST_IDLE && xfer_func != 2'd0) |=> start_req);

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !xfer_busy && !is_clear) |=> start_req);

endmodule

bind dsk_csr dsk_csr_chk #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_strobe (io_strobe),
    .io_dev    (io_dev),
    .io_pulse  (io_pulse),
    .io_subop  (io_subop),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .io_skip   (io_skip),
    .start_req (start_req),
    .xfer_func (xfer_func),
    .disk_addr (disk_addr),
    .xfer_busy (xfer_busy),
    .ctl_state (ctl_state)
);

// File: tb/dsk_csr_bench.sv
`timescale 1ns/1ps
module dsk_csr_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_strobe = 1'b0;
    logic        io_dev = 1'b0;
    logic [2:0]  io_pulse = 3'b000;
    logic [1:0]  io_subop = 2'b00;
    logic [17:0] io_wdata = '0;
    logic [17:0] io_rdata;
    logic        io_skip;
    logic        irq;
    logic        start_req;
    logic [1:0]  xfer_func;
    logic [20:0] disk_addr;
    logic        xfer_busy = 1'b0;
    logic        xfer_done = 1'b0;
    logic [7:0]  xfer_flags = '0;
    logic [3:0]  platters = 4'd8;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dsk_csr u_dsk_csr (
        .clk(clk), .rst_n(rst_n), .io_strobe(io_strobe), .io_dev(io_dev),
        .io_pulse(io_pulse), .io_subop(io_subop), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_skip(io_skip), .irq(irq), .start_req(start_req),
        .xfer_func(xfer_func), .disk_addr(disk_addr), .xfer_busy(xfer_busy),
        .xfer_done(xfer_done), .xfer_flags(xfer_flags), .platters(platters)
    );

    // ---------------- reference model ----------------
    int m_sta, m_da, m_buf, m_state, m_rd, m_sk;
    int s, a, b, rdv, skv, nst;
    bit bz, lau, clr;

    function automatic int summ(input int v);
        return (((v >> 10) & 'h7F) != 0) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sta = 0; m_da = 0; m_buf = 0; m_state = 0; m_rd = 0; m_sk = 0;
        end else begin
            s = m_sta; a = m_da; b = m_buf; rdv = 0; skv = 0;
            bz = (m_state != 0); lau = 0; clr = 0; nst = m_state;
            if (io_strobe) begin
                if (!io_dev) begin
                    if (io_pulse[0]) begin
                        if (io_subop == 0) skv = (summ(s) != 0 || (s & 'h80) != 0) ? 1 : 0;
                        else if (io_subop == 1) begin s = 0; a = 0; b = 0; bz = 0; clr = 1; end
                        else if (io_subop == 2) begin
                            if (bz) s = s | 'h100; else s = s & ~7;
                        end
                    end
                    if (io_pulse[1]) begin
                        if (bz) s = s | 'h100;
                        else if (io_subop == 0) rdv = b;
                        else if (io_subop == 1) rdv = a & 'h3FFFF;
                        else if (io_subop == 2) s = s ^ (int'(io_wdata) & 7);
                        else rdv = (a >> 18) | (((s >> 10) & 1) << 3);
                    end
                    if (io_pulse[2]) begin
                        if (bz) s = s | 'h100;
                        else if (io_subop == 0) b = int'(io_wdata);
                        else if (io_subop == 1) a = (a & ~'h3FFFF) | int'(io_wdata);
                        else if (io_subop == 2) begin
                            s = s & ~'h80;
                            if (((s >> 1) & 3) != 0) lau = 1;
                        end else begin
                            a = (a & 'h3FFFF) | ((int'(io_wdata) & 7) << 18);
                            if ((int'(io_wdata) & 7) >= int'(platters)) s = s | 'h400;
                        end
                    end
                end else if (io_pulse[1]) begin
                    if (io_subop == 2) begin
                        if (bz) s = s | 'h100; else s = s & 7;
                    end else if (io_subop == 3) begin
                        if (bz) s = s | 'h100;
                        rdv = s | (summ(s) << 17);
                    end
                end
            end
            s = s | (int'(xfer_flags) << 9);
            if (xfer_done) s = s | 'h80;
            if (clr) nst = 0;
            else if (lau) nst = 1;
            else if (m_state == 1 && xfer_busy) nst = 2;
            else if (m_state == 2 && !xfer_busy) nst = 0;
            m_sta = s; m_da = a; m_buf = b; m_state = nst; m_rd = rdv; m_sk = skv;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R11 rdata", int'(io_rdata), m_rd);
            chk("R10 skip", int'(io_skip), m_sk);
            chk("R3 irq", int'(irq), ((summ(m_sta) != 0 || (m_sta & 'h80) != 0) && (m_sta & 1) != 0) ? 1 : 0);
            chk("R6 start_req", int'(start_req), (m_state == 1) ? 1 : 0);
            chk("R4 func", int'(xfer_func), (m_sta >> 1) & 3);
            chk("R7 addr", int'(disk_addr), m_da);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    logic [17:0] r;
    logic        k;

    task automatic instr(input logic d, input logic [2:0] p, input logic [1:0] sb,
                         input logic [17:0] w, output logic [17:0] ro, output logic ko);
        @(negedge clk);
        io_strobe = 1'b1; io_dev = d; io_pulse = p; io_subop = sb; io_wdata = w;
        @(negedge clk);
        io_strobe = 1'b0; io_pulse = 3'b000; io_wdata = '0;
        ro = io_rdata; ko = io_skip;
    endtask

    task automatic ctl_clear();
        instr(1'b0, 3'b001, 2'd1, '0, r, k);
    endtask

    task automatic rd_status(output logic [17:0] ro);
        logic kk;
        instr(1'b1, 3'b010, 2'd3, '0, ro, kk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset irq", int'(irq), 0);
        chk("R1 reset start_req", int'(start_req), 0);
        chk("R1 reset addr", int'(disk_addr), 0);
        rd_status(r); chk("R1 reset status", int'(r), 0);

        // buffer and address paths
        instr(0, 3'b100, 2'd0, 18'h2A5A5, r, k);
        instr(0, 3'b010, 2'd0, '0, r, k);  chk("R7 buffer read", int'(r), 'h2A5A5);
        instr(0, 3'b100, 2'd1, 18'h3FFFF, r, k);
        instr(0, 3'b010, 2'd1, '0, r, k);  chk("R7 low addr read", int'(r), 'h3FFFF);
        instr(0, 3'b100, 2'd3, 18'h5, r, k);
        instr(0, 3'b010, 2'd3, '0, r, k);  chk("R7 high addr read", int'(r), 5);
        chk("R7 disk_addr", int'(disk_addr), 'h17FFFF);
        @(negedge clk); chk("R11 quiet rdata", int'(io_rdata), 0);

        // capacity check
        platters = 4'd2;
        instr(0, 3'b100, 2'd3, 18'h1, r, k);
        instr(0, 3'b010, 2'd3, '0, r, k);  chk("R8 below capacity", int'(r), 1);
        instr(0, 3'b100, 2'd3, 18'h2, r, k);
        instr(0, 3'b010, 2'd3, '0, r, k);  chk("R8 at capacity", int'(r), 'hA);
        rd_status(r); chk("R2 nxd summary", int'(r), 'h20400);
        instr(0, 3'b001, 2'd0, '0, r, k);  chk("R10 skip on error", int'(k), 1);

        // function field, interrupt, clears
        instr(0, 3'b010, 2'd2, 18'h3, r, k);
        chk("R3 irq on error", int'(irq), 1);
        instr(1, 3'b010, 2'd2, '0, r, k);
        rd_status(r); chk("R9 clear errors", int'(r), 3);
        chk("R3 irq no cause", int'(irq), 0);
        instr(0, 3'b001, 2'd0, '0, r, k);  chk("R10 no skip", int'(k), 0);
        instr(0, 3'b010, 2'd2, 18'h6, r, k);
        chk("R4 xor func", int'(xfer_func), 2);
        instr(0, 3'b001, 2'd2, '0, r, k);
        rd_status(r); chk("R9 clear function", int'(r), 0);

        // start handshake
        platters = 4'd8;
        instr(0, 3'b100, 2'd2, '0, r, k);
        chk("R6 nop no start", int'(start_req), 0);
        instr(0, 3'b010, 2'd2, 18'h2, r, k);
        instr(0, 3'b100, 2'd2, '0, r, k);
        chk("R6 start_req", int'(start_req), 1);
        repeat (2) @(negedge clk);
        chk("R6 start_req held", int'(start_req), 1);
        xfer_busy = 1'b1;
        @(negedge clk);
        chk("R6 active drops req", int'(start_req), 0);
        instr(0, 3'b100, 2'd1, 18'h00000, r, k);
        chk("R5 blocked load", int'(disk_addr), 'h0BFFFF);
        instr(0, 3'b010, 2'd0, '0, r, k);  chk("R5 blocked read", int'(r), 0);
        rd_status(r); chk("R5 status while busy", int'(r), 'h102);
        @(negedge clk); xfer_busy = 1'b0; xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
        rd_status(r); chk("R6 done set", int'(r), 'h182);
        instr(0, 3'b001, 2'd0, '0, r, k);  chk("R10 skip on done", int'(k), 1);
        instr(0, 3'b010, 2'd2, 18'h1, r, k);
        chk("R3 irq on done", int'(irq), 1);
        instr(0, 3'b100, 2'd2, '0, r, k);
        rd_status(r); chk("R6 start clears done", int'(r), 'h103);
        ctl_clear();
        chk("R1 clear in request", int'(start_req), 0);
        chk("R1 clear addr", int'(disk_addr), 0);
        rd_status(r); chk("R1 clear status", int'(r), 0);

        // sequencer flags
        @(negedge clk); xfer_flags = 8'h01;
        @(negedge clk); xfer_flags = 8'h00;
        rd_status(r); chk("R2 channel flag no summary", int'(r), 'h200);
        @(negedge clk); xfer_flags = 8'h80;
        @(negedge clk); xfer_flags = 8'h00;
        rd_status(r); chk("R2 hardware flag summary", int'(r), 'h30200);
        ctl_clear();

        // phase ordering within one instruction
        instr(0, 3'b100, 2'd0, 18'h12345, r, k);
        instr(0, 3'b110, 2'd0, 18'h00777, r, k); chk("R12 read before load", int'(r), 'h12345);
        instr(0, 3'b010, 2'd0, '0, r, k);         chk("R12 load applied", int'(r), 'h777);
        instr(0, 3'b100, 2'd1, 18'h155, r, k);
        instr(0, 3'b011, 2'd1, '0, r, k);         chk("R12 clear then read", int'(r), 0);
        chk("R12 clear addr", int'(disk_addr), 0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule